// File: doc/BRIEF.md
# Bouncing Two-Digit Decimal Counter

This block is a synchronous two-digit decimal counter. Its value runs between 00 and 67. It does not wrap at the ends: it turns around. Coming down, it reaches 00 and then climbs back. Going up, it reaches 67 and then falls again. A single direction bit, kept in a register, chooses whether each enabled clock adds or subtracts one. The low digit is a four-bit decimal digit that cycles through 0 to 9. Its carry, or its borrow, moves the high digit, which holds 0 to 6 internally.

Each turnaround is folded into the step that lands on the limit. The direction bit that is shown beside 67 is already "down", and the one shown beside 00 is already "up". Each limit therefore holds for exactly one enabled tick. Synchronous reset and the load strobe both preset the count to 67, heading down, so the first pass starts with the low digit at 7 instead of 9. Both digits leave the block as four-bit values, the high one zero-extended, so that they can feed two hex display decoders outside this block.

Top module: `bounce_bcd_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state is ones 7, tens 6, `dir_o` = 1 (1 means counting down, 0 means counting up). This holds whatever `en` and `load` are.
- R2: With `rst` low and `load` high, the next state is 67 with `dir_o` = 1. This holds whether `en` is high or low.
- R3: With `rst`, `load` and `en` all low, the digits and `dir_o` keep their values across the edge.
- R4: With `en` high, `dir_o` = 1 and no reset or load, the count drops by one in decimal. A ones digit of 0 becomes 9 and borrows one from the tens digit.
- R5: With `en` high, `dir_o` = 0 and no reset or load, the count rises by one in decimal. A ones digit of 9 becomes 0 and carries one into the tens digit.
- R6: A down step that lands on 00 sets `dir_o` to 0 in that same edge, so the next enabled step gives 01.
- R7: An up step that lands on 67 sets `dir_o` to 1 in that same edge, so the next enabled step gives 66.
- R8: After reset, `ones_o` never exceeds 9, `tens_o` never exceeds 6, and bit 3 of `tens_o` is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset to 67 counting down |
| en | input | 1 | Step enable; low holds all state |
| load | input | 1 | Preset strobe to 67 counting down; overrides en |
| ones_o | output | 4 | Low decimal digit |
| tens_o | output | 4 | High decimal digit, zero-extended |
| dir_o | output | 1 | Current direction, 1 = down, 0 = up |

## Verification
Two cases can arise in the same cycle, and both need checking. The first is a load strobe arriving together with an enabled step, including a step that would itself reach a limit and turn around. The second is a limit being reached in the very step that flips the direction. Random enable and load traffic, plus directed cases that raise load and enable together at 66, 01 and mid-range, provoke both. A bench model in which load always wins, and in which the direction is decided from the value just reached, judges every cycle.

// File: rtl/bounce_bcd_pkg.sv
package bounce_bcd_pkg;
   typedef enum logic {
      DIR_UP = 1'b0,
      DIR_DN = 1'b1
   } dir_e;

   localparam int DEC_RADIX = 10;
endpackage

// File: rtl/bcd_digit_step.sv
module bcd_digit_step #(
   parameter int W     = 4,
   parameter int RADIX = 10
) (
   input  logic [W-1:0] digit_i,
   input  logic         step_i,
   input  logic         down_i,
   output logic [W-1:0] digit_o,
   output logic         ripple_o
);
   localparam logic [W-1:0] LAST = W'(RADIX - 1);

   if (RADIX < 2 || RADIX > (1 << W)) begin : g_bad_radix
      $error("bcd_digit_step: RADIX does not fit W");
   end

   always_comb begin
      digit_o  = digit_i;
      ripple_o = 1'b0;
      if (step_i) begin
         if (down_i) begin
            if (digit_i == '0) begin
               digit_o  = LAST;
               ripple_o = 1'b1;
            end else begin
               digit_o = digit_i - 1'b1;
            end
         end else begin
            if (digit_i == LAST) begin
               digit_o  = '0;
               ripple_o = 1'b1;
            end else begin
               digit_o = digit_i + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/bounce_turn.sv
module bounce_turn
   import bounce_bcd_pkg::*;
#(
   parameter int ONES_W   = 4,
   parameter int TENS_W   = 3,
   parameter int TOP_ONES = 7,
   parameter int TOP_TENS = 6
) (
   input  dir_e              dir_i,
   input  logic [ONES_W-1:0] ones_nx_i,
   input  logic [TENS_W-1:0] tens_nx_i,
   output dir_e              dir_o
);
   localparam logic [ONES_W-1:0] HI_ONES = ONES_W'(TOP_ONES);
   localparam logic [TENS_W-1:0] HI_TENS = TENS_W'(TOP_TENS);

   logic at_top, at_bottom;

   always_comb begin
      at_top    = (ones_nx_i == HI_ONES) && (tens_nx_i == HI_TENS);
      at_bottom = (ones_nx_i == '0) && (tens_nx_i == '0);
      dir_o     = dir_i;
      if (dir_i == DIR_UP && at_top)    dir_o = DIR_DN;
      if (dir_i == DIR_DN && at_bottom) dir_o = DIR_UP;
   end
endmodule

// File: rtl/bounce_bcd_counter.sv
module bounce_bcd_counter
   import bounce_bcd_pkg::*;
#(
   parameter int ONES_W   = 4,
   parameter int TENS_W   = 3,
   parameter int OUT_W    = 4,
   parameter int TOP_ONES = 7,
   parameter int TOP_TENS = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             load,
   output logic [OUT_W-1:0] ones_o,
   output logic [OUT_W-1:0] tens_o,
   output logic             dir_o
);
   localparam logic [ONES_W-1:0] PRE_ONES = ONES_W'(TOP_ONES);
   localparam logic [TENS_W-1:0] PRE_TENS = TENS_W'(TOP_TENS);

   if (TOP_ONES > DEC_RADIX - 1) begin : g_bad_top_ones
      $error("bounce_bcd_counter: TOP_ONES must be a decimal digit");
   end
   if (TOP_TENS >= (1 << TENS_W) || TOP_TENS > DEC_RADIX - 1) begin : g_bad_top_tens
      $error("bounce_bcd_counter: TOP_TENS does not fit TENS_W");
   end
   if (OUT_W < ONES_W || OUT_W < TENS_W) begin : g_bad_out_w
      $error("bounce_bcd_counter: OUT_W narrower than a digit");
   end
   if (ONES_W < 4) begin : g_bad_ones_w
      $error("bounce_bcd_counter: ONES_W must hold 0..9");
   end

   logic [ONES_W-1:0] ones_q, ones_nx;
   logic [TENS_W-1:0] tens_q, tens_nx;
   dir_e              dir_q, dir_nx;
   logic              ones_rip, tens_rip;
   logic              going_down;

   assign going_down = (dir_q == DIR_DN);

   bcd_digit_step #(.W(ONES_W), .RADIX(DEC_RADIX)) u_ones (
      .digit_i (ones_q),
      .step_i  (1'b1),
      .down_i  (going_down),
      .digit_o (ones_nx),
      .ripple_o(ones_rip)
   );

   bcd_digit_step #(.W(TENS_W), .RADIX(TOP_TENS + 1)) u_tens (
      .digit_i (tens_q),
      .step_i  (ones_rip),
      .down_i  (going_down),
      .digit_o (tens_nx),
      .ripple_o(tens_rip)
   );

   bounce_turn #(
      .ONES_W(ONES_W), .TENS_W(TENS_W),
      .TOP_ONES(TOP_ONES), .TOP_TENS(TOP_TENS)
   ) u_turn (
      .dir_i    (dir_q),
      .ones_nx_i(ones_nx),
      .tens_nx_i(tens_nx),
      .dir_o    (dir_nx)
   );

   always_ff @(posedge clk) begin
      if (rst || load) begin
         ones_q <= PRE_ONES;
         tens_q <= PRE_TENS;
         dir_q  <= DIR_DN;
      end else if (en) begin
         ones_q <= ones_nx;
         tens_q <= tens_nx;
         dir_q  <= dir_nx;
      end
   end

   if (OUT_W == ONES_W) begin : g_ones_same
      assign ones_o = ones_q;
   end else begin : g_ones_ext
      assign ones_o = {{(OUT_W - ONES_W){1'b0}}, ones_q};
   end

   if (OUT_W == TENS_W) begin : g_tens_same
      assign tens_o = tens_q;
   end else begin : g_tens_ext
      assign tens_o = {{(OUT_W - TENS_W){1'b0}}, tens_q};
   end

   assign dir_o = dir_q;

   logic unused_rip;
   assign unused_rip = tens_rip;
endmodule

// File: rtl/bounce_bcd_counter_chk.sv
module bounce_bcd_counter_chk #(
   parameter int OUT_W = 4
) (
   input logic             clk,
   input logic             rst,
   input logic             en,
   input logic             load,
   input logic [OUT_W-1:0] ones_o,
   input logic [OUT_W-1:0] tens_o,
   input logic             dir_o
);
   logic preset_seen;
   assign preset_seen = (ones_o == OUT_W'(7)) && (tens_o == OUT_W'(6)) && dir_o;

   assert_reset_value_R1: assert property (@(posedge clk)
      rst |=> preset_seen);

   assert_load_preset_R2: assert property (@(posedge clk) disable iff (rst)
      load |=> preset_seen);

   assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (!load && !en) |=> ($stable(ones_o) && $stable(tens_o) && $stable(dir_o)));

   assert_step_down_R4: assert property (@(posedge clk) disable iff (rst)
      (en && !load && dir_o && ones_o != '0) |=>
         (ones_o == $past(ones_o) - 1'b1 && tens_o == $past(tens_o)));

   assert_borrow_R4: assert property (@(posedge clk) disable iff (rst)
      (en && !load && dir_o && ones_o == '0) |=>
         (ones_o == OUT_W'(9) && tens_o == $past(tens_o) - 1'b1));

   assert_step_up_R5: assert property (@(posedge clk) disable iff (rst)
      (en && !load && !dir_o && ones_o != OUT_W'(9)) |=>
         (ones_o == $past(ones_o) + 1'b1 && tens_o == $past(tens_o)));

   assert_carry_R5: assert property (@(posedge clk) disable iff (rst)
      (en && !load && !dir_o && ones_o == OUT_W'(9)) |=>
         (ones_o == '0 && tens_o == $past(tens_o) + 1'b1));

   assert_bottom_turn_R6: assert property (@(posedge clk) disable iff (rst)
      (ones_o == '0 && tens_o == '0) |-> !dir_o);

   assert_top_turn_R7: assert property (@(posedge clk) disable iff (rst)
      (ones_o == OUT_W'(7) && tens_o == OUT_W'(6)) |-> dir_o);

   assert_range_R8: assert property (@(posedge clk) disable iff (rst)
      (ones_o <= OUT_W'(9) && tens_o <= OUT_W'(6) && !tens_o[3]));
endmodule

bind bounce_bcd_counter bounce_bcd_counter_chk #(.OUT_W(OUT_W)) u_chk (
   .clk   (clk),
   .rst   (rst),
   .en    (en),
   .load  (load),
   .ones_o(ones_o),
   .tens_o(tens_o),
   .dir_o (dir_o)
);

// File: tb/sim_bounce_bcd_counter.sv
`timescale 1ns/1ps
module sim_bounce_bcd_counter;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en = 1'b0;
   logic       load = 1'b0;
   logic [3:0] ones_o, tens_o;
   logic       dir_o;

   int  n_vec = 0;
   int  n_bad = 0;
   int  mv = 67;
   bit  md = 1'b1;
   int  cyc = 0;
   bit  done = 1'b0;

   always #10 clk = ~clk;

   bounce_bcd_counter u0 (
      .clk(clk), .rst(rst), .en(en), .load(load),
      .ones_o(ones_o), .tens_o(tens_o), .dir_o(dir_o)
   );

   function automatic int next_val(int v, bit d);
      return d ? v - 1 : v + 1;
   endfunction

   function automatic bit next_dir(int nv, bit d);
      if (!d && nv == 67) return 1'b1;
      if (d && nv == 0)   return 1'b0;
      return d;
   endfunction

   task automatic check(string tag);
      int eo = mv % 10;
      int et = mv / 10;
      n_vec++;
      if (ones_o !== 4'(eo) || tens_o !== 4'(et) || dir_o !== md) begin
         n_bad++;
         $display("FAIL %s: got tens=%0d ones=%0d dir=%0b expected tens=%0d ones=%0d dir=%0b",
                  tag, tens_o, ones_o, dir_o, et, eo, md);
      end
      n_vec++;
      if (ones_o > 4'd9 || tens_o > 4'd6 || tens_o[3] !== 1'b0) begin
         n_bad++;
         $display("FAIL R8: got tens=%0d ones=%0d expected tens<=6 ones<=9", tens_o, ones_o);
      end
   endtask

   task automatic step(bit r, bit e, bit l);
      string tag;
      int nv;
      rst = r; en = e; load = l;
      if (r) begin
         tag = "R1"; mv = 67; md = 1'b1;
      end else if (l) begin
         tag = "R2"; mv = 67; md = 1'b1;
      end else if (!e) begin
         tag = "R3";
      end else begin
         nv = next_val(mv, md);
         if (md && nv == 0)        tag = "R6";
         else if (!md && nv == 67) tag = "R7";
         else if (md)              tag = "R4";
         else                      tag = "R5";
         md = next_dir(nv, md);
         mv = nv;
      end
      @(negedge clk);
      check(tag);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog: got no end after %0d cycles expected finish", cyc);
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'h5EED_0067));
      @(negedge clk);
      step(1, 1, 1);            // R1 reset wins over load/en
      step(0, 0, 0);            // R3 hold at 67
      step(0, 0, 0);
      for (int i = 0; i < 140; i++) step(0, 1, 0);   // full bounce: R4 R5 R6 R7
      step(0, 0, 0);            // R3 hold mid-range
      step(0, 1, 1);            // R2 load with enable
      for (int i = 0; i < 66; i++) step(0, 1, 0);    // down to 01
      step(0, 1, 1);            // R2 load where step would hit 00
      for (int i = 0; i < 67; i++) step(0, 1, 0);    // to 00, R6
      for (int i = 0; i < 66; i++) step(0, 1, 0);    // up to 66
      step(0, 1, 1);            // R2 load where step would hit 67
      step(0, 1, 0);
      step(0, 0, 1);            // R2 load without enable
      for (int i = 0; i < 3000; i++) begin
         bit r = ($urandom % 64) == 0;
         bit l = ($urandom % 16) == 0;
         bit e = ($urandom % 4) != 0;
         step(r, e, l);
      end
      done = 1'b1;
      finish_run();
   end
endmodule